// File: doc/BRIEF.md
# Watermark-Driven Data FIFO with DMA Requests

This block is a 32-word, 16-bit circular buffer. It sits between a host data port and a card-side byte engine, and it moves words in one direction at a time. In the receive direction the card side pushes words and the host pops them. In the transmit direction the host pushes words and the card side pops them. The card side appears here only as push and pop strobes.

The block compares the fill count with two programmable levels, one for almost-full and one for almost-empty. For each direction, a per-direction enable in the buffer configuration word selects the response to a crossed level. With the enable set, the block raises a DMA request line. With the enable clear, it raises a status flag. Both status flags are forced low while no transfer is running and the buffer is empty. A host read from an empty buffer sets a sticky underrun indication and moves nothing.

Top module: `watermark_fifo`

## Requirements
- R1: Words leave in the order they entered, up to 32 held at once. `headData` always shows the oldest held word, and `fillLevel` gives the number held (0 to 32).
- R2: While `dirRx` is 1, `cardPushEn` pushes `cardPushData` and `hostRdEn` pops. While `dirRx` is 0, `hostWrEn` pushes `hostWrData` and `cardPopEn` pops. The push and pop strobes that do not belong to the current direction have no effect.
- R3: A push while 32 words are held is discarded, and neither the fill level nor the contents change.
- R4: A host read in the receive direction while the buffer is empty sets `underrun`. The read moves no pointer, and `headData` keeps showing the word at the current start slot. A card pop while the buffer is empty is ignored.
- R5: The configuration word has these fields: bit 15 enables receive DMA, bits 12:8 hold the almost-full level, bit 7 enables transmit DMA, and bits 4:0 hold the almost-empty level. All other bits read as 0. `cfgRdData` returns the word, and its reset value is 0x1F00.
- R6: In the receive direction, when the fill level is above the almost-full level, `rxDmaReq` is 1 and `statusAf` is 0 if receive DMA is enabled. If receive DMA is disabled, `statusAf` is 1 and `rxDmaReq` is 0.
- R7: In the transmit direction, when the fill level is below the almost-empty level, `txDmaReq` is 1 and `statusAe` is 0 if transmit DMA is enabled. If transmit DMA is disabled, `statusAe` is 1 and `txDmaReq` is 0.
- R8: When a direction's level condition does not hold, or the other direction is selected, that direction's DMA request and status flag are both 0.
- R9: While `xferActive` is 0 and the fill level is 0, `statusAf` and `statusAe` are both 0.
- R10: A configuration write changes `cfgRdData`, the DMA requests and the status flags from the cycle after the write.
- R11: `underrun` stays 1 from the cycle after an empty host read until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dirRx | input | 1 | 1 = receive (card to host), 0 = transmit |
| xferActive | input | 1 | A data transfer is in progress |
| cfgWrEn | input | 1 | Write strobe for the configuration word |
| cfgWrData | input | 16 | Configuration word to write |
| cfgRdData | output | 16 | Current configuration word |
| hostWrEn | input | 1 | Host write to the data port |
| hostWrData | input | 16 | Host write data |
| hostRdEn | input | 1 | Host read from the data port |
| cardPushEn | input | 1 | Card-side push strobe |
| cardPushData | input | 16 | Card-side push data |
| cardPopEn | input | 1 | Card-side pop strobe |
| headData | output | 16 | Word at the start slot |
| fillLevel | output | 6 | Number of words held |
| rxDmaReq | output | 1 | Receive DMA request |
| txDmaReq | output | 1 | Transmit DMA request |
| statusAf | output | 1 | Almost-full status flag |
| statusAe | output | 1 | Almost-empty status flag |
| underrun | output | 1 | Sticky empty-read indication |

## Verification
The hardest case to reach is an empty host read whose returned word can be predicted: the start slot must hold a known stale value. The stimulus reaches it in four steps. It first fills the buffer through the host side with 33 writes, the last of which is discarded. It then switches to the receive direction and drains all 32 words with host reads, which brings the start index back to slot 0, where the first word was written. The empty read that follows must return that first word and set the sticky flag. After that, a long random phase changes the direction, the configuration and the strobe densities, and it is compared on every cycle against a queue-based model.

// File: rtl/wmfifo_pkg.sv
package wmfifo_pkg;
  // Strobes issued by the control unit to the storage datapath
  typedef struct packed {
    logic push;          // accepted push this cycle
    logic pop;           // accepted pop this cycle
    logic pushFromHost;  // push data source: 1 = host port, 0 = card side
  } fifoStrobes_t;
endpackage

// File: rtl/wmfifo_datapath.sv
module wmfifo_datapath
  import wmfifo_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int WIDTH = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  fifoStrobes_t               strobes,
  input  logic [WIDTH-1:0]           pushData,
  output logic [WIDTH-1:0]           headData,
  output logic [$clog2(DEPTH):0]     fillCount
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    startIdx;
  logic [AW-1:0]    writeIdx;

  // write slot is start plus count, wrapping at the buffer size
  assign writeIdx = startIdx + fillCount[AW-1:0];
  assign headData = mem[startIdx];

  always_ff @(posedge clk) begin
    if (strobes.push) mem[writeIdx] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startIdx  <= '0;
      fillCount <= '0;
    end else begin
      if (strobes.pop) startIdx <= startIdx + AW'(1);
      case ({strobes.push, strobes.pop})
        2'b10:   fillCount <= fillCount + CW'(1);
        2'b01:   fillCount <= fillCount - CW'(1);
        default: fillCount <= fillCount;
      endcase
    end
  end

  // R1: count never exceeds capacity
  a_r1_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    fillCount <= CW'(DEPTH));
  // R3: control never issues a push into a full buffer
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    (fillCount == CW'(DEPTH)) |-> !strobes.push);
  // R4: nothing moves the start slot while empty
  a_r4_empty_start_hold: assert property (@(posedge clk) disable iff (!rstN)
    (fillCount == '0) |=> $stable(startIdx));
endmodule

// File: rtl/wmfifo_ctrl.sv
module wmfifo_ctrl
  import wmfifo_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   dirRx,
  input  logic                   xferActive,
  input  logic                   cfgWrEn,
  input  logic [15:0]            cfgWrData,
  input  logic                   hostWrEn,
  input  logic                   hostRdEn,
  input  logic                   cardPushEn,
  input  logic                   cardPopEn,
  input  logic [$clog2(DEPTH):0] fillCount,
  output fifoStrobes_t           strobes,
  output logic [15:0]            cfgRdData,
  output logic                   rxDmaReq,
  output logic                   txDmaReq,
  output logic                   statusAf,
  output logic                   statusAe,
  output logic                   underrun
);
  localparam int AW       = $clog2(DEPTH);
  localparam int CW       = AW + 1;
  localparam int LVLW     = AW;
  localparam int RXEN_BIT = 15;
  localparam int AF_LSB   = 8;
  localparam int TXEN_BIT = 7;
  localparam int AE_LSB   = 0;
  localparam logic [15:0] CFG_MASK  = 16'h9F9F;
  localparam logic [15:0] CFG_RESET = 16'h1F00;

  logic [15:0]     cfgReg;
  logic [LVLW-1:0] afLevel, aeLevel;
  logic            rxDmaEn, txDmaEn;
  logic            isEmpty, isFull, idleEmpty, rxCross, txCross;
  logic            pushReq, popReq;

  assign rxDmaEn = cfgReg[RXEN_BIT];
  assign txDmaEn = cfgReg[TXEN_BIT];
  assign afLevel = cfgReg[AF_LSB +: LVLW];
  assign aeLevel = cfgReg[AE_LSB +: LVLW];
  assign cfgRdData = cfgReg;

  always_ff @(posedge clk) begin
    if (!rstN)        cfgReg <= CFG_RESET;
    else if (cfgWrEn) cfgReg <= cfgWrData & CFG_MASK;
  end

  // direction routing of the four strobes
  assign isEmpty = (fillCount == '0);
  assign isFull  = (fillCount == CW'(DEPTH));
  assign pushReq = dirRx ? cardPushEn : hostWrEn;
  assign popReq  = dirRx ? hostRdEn   : cardPopEn;

  always_comb begin
    strobes.push         = pushReq && !isFull;
    strobes.pop          = popReq  && !isEmpty;
    strobes.pushFromHost = !dirRx;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                            underrun <= 1'b0;
    else if (dirRx && hostRdEn && isEmpty) underrun <= 1'b1;
  end

  // watermark evaluation from registered count and configuration
  assign idleEmpty = !xferActive && isEmpty;
  assign rxCross   = dirRx  && (fillCount > {1'b0, afLevel});
  assign txCross   = !dirRx && (fillCount < {1'b0, aeLevel});

  assign rxDmaReq = rxCross && rxDmaEn;
  assign txDmaReq = txCross && txDmaEn;
  assign statusAf = rxCross && !rxDmaEn && !idleEmpty;
  assign statusAe = txCross && !txDmaEn && !idleEmpty;

  // R6: request and flag never together in receive
  a_r6_rx_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(rxDmaReq && statusAf));
  // R7: request and flag never together in transmit
  a_r7_tx_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(txDmaReq && statusAe));
  // R8: below almost-full, receive outputs stay low
  a_r8_rx_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (fillCount <= {1'b0, afLevel}) |-> (!rxDmaReq && !statusAf));
  // R9: idle and empty clears both flags
  a_r9_idle_clear: assert property (@(posedge clk) disable iff (!rstN)
    (!xferActive && isEmpty) |-> (!statusAf && !statusAe));
  // R10: configuration visible the cycle after the write
  a_r10_cfg_next: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrEn |=> (cfgRdData == $past(cfgWrData & CFG_MASK)));
  // R11: underrun is sticky
  a_r11_underrun_sticky: assert property (@(posedge clk) disable iff (!rstN)
    underrun |=> underrun);
endmodule

// File: rtl/watermark_fifo.sv
module watermark_fifo
  import wmfifo_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int WIDTH = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   dirRx,
  input  logic                   xferActive,
  input  logic                   cfgWrEn,
  input  logic [15:0]            cfgWrData,
  output logic [15:0]            cfgRdData,
  input  logic                   hostWrEn,
  input  logic [WIDTH-1:0]       hostWrData,
  input  logic                   hostRdEn,
  input  logic                   cardPushEn,
  input  logic [WIDTH-1:0]       cardPushData,
  input  logic                   cardPopEn,
  output logic [WIDTH-1:0]       headData,
  output logic [$clog2(DEPTH):0] fillLevel,
  output logic                   rxDmaReq,
  output logic                   txDmaReq,
  output logic                   statusAf,
  output logic                   statusAe,
  output logic                   underrun
);
  fifoStrobes_t     strobes;
  logic [WIDTH-1:0] pushData;

  assign pushData = strobes.pushFromHost ? hostWrData : cardPushData;

  wmfifo_ctrl #(.DEPTH(DEPTH)) ctrl (
    .clk(clk), .rstN(rstN), .dirRx(dirRx), .xferActive(xferActive),
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .hostWrEn(hostWrEn), .hostRdEn(hostRdEn),
    .cardPushEn(cardPushEn), .cardPopEn(cardPopEn),
    .fillCount(fillLevel), .strobes(strobes), .cfgRdData(cfgRdData),
    .rxDmaReq(rxDmaReq), .txDmaReq(txDmaReq),
    .statusAf(statusAf), .statusAe(statusAe), .underrun(underrun)
  );

  wmfifo_datapath #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .pushData(pushData),
    .headData(headData), .fillCount(fillLevel)
  );
endmodule

// File: tb/watermark_fifo_test.sv
module watermark_fifo_test;
  logic clk = 0;
  logic rstN = 0;
  logic dirRx = 0, xferActive = 0, cfgWrEn = 0, hostWrEn = 0, hostRdEn = 0;
  logic cardPushEn = 0, cardPopEn = 0;
  logic [15:0] cfgWrData = 0, hostWrData = 0, cardPushData = 0;
  logic [15:0] cfgRdData, headData;
  logic [5:0]  fillLevel;
  logic rxDmaReq, txDmaReq, statusAf, statusAe, underrun;

  int checks = 0, fails = 0;
  bit finished = 0;

  // behavioural model state
  int q[$];
  int mAf = 31, mAe = 0;
  bit mRxEn = 0, mTxEn = 0, mUnder = 0;

  always #5 clk = ~clk;

  watermark_fifo uut (
    .clk(clk), .rstN(rstN), .dirRx(dirRx), .xferActive(xferActive),
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData), .cfgRdData(cfgRdData),
    .hostWrEn(hostWrEn), .hostWrData(hostWrData), .hostRdEn(hostRdEn),
    .cardPushEn(cardPushEn), .cardPushData(cardPushData), .cardPopEn(cardPopEn),
    .headData(headData), .fillLevel(fillLevel), .rxDmaReq(rxDmaReq),
    .txDmaReq(txDmaReq), .statusAf(statusAf), .statusAe(statusAe),
    .underrun(underrun)
  );

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic checkAll();
    int  cnt = q.size();
    bit  rxc = dirRx && (cnt > mAf);
    bit  txc = !dirRx && (cnt < mAe);
    bit  idle = !xferActive && (cnt == 0);
    int  expCfg = (int'(mRxEn) << 15) | (mAf << 8) | (int'(mTxEn) << 7) | mAe;
    chk(fillLevel == cnt, "R1/R2/R3 fill level", fillLevel, cnt);
    if (cnt > 0) chk(headData == q[0], "R1 head order", headData, q[0]);
    chk(cfgRdData == expCfg, "R5/R10 config readback", cfgRdData, expCfg);
    chk(rxDmaReq == (rxc && mRxEn), "R6/R8 rxDmaReq", rxDmaReq, rxc && mRxEn);
    chk(statusAf == (rxc && !mRxEn && !idle), "R6/R9 statusAf", statusAf, rxc && !mRxEn && !idle);
    chk(txDmaReq == (txc && mTxEn), "R7/R8 txDmaReq", txDmaReq, txc && mTxEn);
    chk(statusAe == (txc && !mTxEn && !idle), "R7/R9 statusAe", statusAe, txc && !mTxEn && !idle);
    chk(underrun == mUnder, "R4/R11 underrun", underrun, mUnder);
  endtask

  // one cycle: drive inputs, advance model, check after the edge
  task automatic tick(bit hw, bit hr, bit cpu, bit cpo, bit cw,
                      logic [15:0] hd, logic [15:0] pd, logic [15:0] cd);
    bit pushAtt, popAtt, doPush, doPop;
    hostWrEn = hw; hostRdEn = hr; cardPushEn = cpu; cardPopEn = cpo;
    cfgWrEn = cw; hostWrData = hd; cardPushData = pd; cfgWrData = cd;
    pushAtt = dirRx ? cpu : hw;
    popAtt  = dirRx ? hr : cpo;
    doPop   = popAtt && q.size() > 0;
    doPush  = pushAtt && q.size() < 32;
    if (dirRx && hr && q.size() == 0) mUnder = 1;
    if (doPop) void'(q.pop_front());
    if (doPush) q.push_back(int'(dirRx ? pd : hd));
    if (cw) begin
      mRxEn = cd[15]; mAf = int'(cd[12:8]); mTxEn = cd[7]; mAe = int'(cd[4:0]);
    end
    @(posedge clk);
    @(negedge clk);
    checkAll();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    checkAll();  // reset state: R5 reset value 0x1F00, empty, all low
    chk(cfgRdData == 16'h1F00, "R5 reset config", cfgRdData, 16'h1F00);

    // R7: transmit, ae level 4, no DMA -> status flag while active
    dirRx = 0; xferActive = 1;
    tick(0, 0, 0, 0, 1, 0, 0, 16'h0004);
    chk(statusAe == 1, "R7 flag after config (R10)", statusAe, 1);

    // R3: 33 host writes, last discarded
    for (int i = 0; i < 33; i++) tick(1, 0, 0, 0, 0, 16'h0100 + 16'(i), 0, 0);
    chk(fillLevel == 32, "R3 full after overflow attempt", fillLevel, 32);

    // R6: receive with DMA, af = 10
    tick(0, 0, 0, 0, 1, 0, 0, 16'h8A84);
    dirRx = 1;
    tick(0, 0, 0, 0, 0, 0, 0, 0);
    chk(rxDmaReq == 1, "R6 rx DMA request when above level", rxDmaReq, 1);

    // R2: drain with host reads; host writes ignored in receive
    for (int i = 0; i < 32; i++) tick(1, 1, 0, 0, 0, 16'hDEAD, 0, 0);
    chk(fillLevel == 0, "R2 drained, host writes ignored", fillLevel, 0);

    // R4: empty read returns stale start word, sets underrun
    chk(headData == 16'h0100, "R4 stale start word", headData, 16'h0100);
    tick(0, 1, 0, 0, 0, 0, 0, 0);
    chk(headData == 16'h0100 && underrun == 1, "R4 empty read", headData, 16'h0100);
    chk(fillLevel == 0, "R4 pointers unchanged", fillLevel, 0);

    // R9: idle and empty clears status flags
    dirRx = 0;
    tick(0, 0, 0, 0, 1, 0, 0, 16'h0010);
    xferActive = 0;
    tick(0, 0, 0, 0, 0, 0, 0, 0);
    chk(statusAe == 0, "R9 idle empty clear", statusAe, 0);

    // random phase, model compared every cycle (R11 sticky kept)
    for (int c = 0; c < 6000; c++) begin
      int bias = (c / 150) % 3;
      if (c % 97 == 0) dirRx = $urandom_range(0, 1);
      if (c % 13 == 0) xferActive = $urandom_range(0, 3) != 0;
      tick($urandom_range(0, 3) < (bias == 0 ? 3 : 1),
           $urandom_range(0, 3) < (bias == 1 ? 3 : 1),
           $urandom_range(0, 3) < (bias == 0 ? 3 : 1),
           $urandom_range(0, 3) < (bias == 1 ? 3 : 1),
           $urandom_range(0, 39) == 0,
           16'($urandom), 16'($urandom), 16'($urandom));
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule